// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block is the host-side master for a 14-bit successive-approximation converter that has a serial output port. On a start request it sends a one-cycle conversion strobe and follows the converter's busy line. It then opens a read window and runs exactly sixteen cycles of a divided shift clock. It samples the serial line on each rising shift-clock edge and keeps the first fourteen bits, most significant first. The finished word is handed over with a single-cycle valid pulse.

There are two operating modes, selected with each start request. In the after-conversion mode the converter uses its own internal clock. The shift clock stays still while busy is high, and the read happens once busy has fallen, so it returns the word just converted. In the during-conversion mode the generated clock drives both the converter's conversion clock and its shift clock. The read window opens straight after the strobe and returns the word from the previous conversion. The clock keeps running until busy falls. In this mode the divider must keep the clock between 30 kHz and 4.5 MHz; a setting outside that range is refused. A sticky flag records a busy line that fails to complete its cycle.

Top module: `sadc_capture_ctrl`

## Requirements
- R1: A start request is accepted only while the synchronised busy line is low. When accepted, `conv_start` is high for exactly one cycle, beginning on the clock edge after the request. A request made while busy is high produces no strobe.
- R2: Each read window contains exactly 16 rising edges of `sclk`. Outside activity `sclk` rests low.
- R3: The serial input is sampled on rising `sclk` edges. The first of the 16 samples becomes `res_data[13]` and the fourteenth becomes `res_data[0]`. Samples 15 and 16 are discarded, whatever their value.
- R4: In after-conversion mode (`mode_sel`=0), `sclk` does not toggle while busy is high. The read window opens only after busy has risen and then fallen, and the read returns the word produced by that conversion.
- R5: In during-conversion mode (`mode_sel`=1), the read window opens right after the strobe while busy is still high, and it returns the word from the preceding conversion. `sclk` keeps running after the window until busy falls, and then it stops low.
- R6: `sclk` stays high for `div_cfg` clock cycles and low for `div_cfg` clock cycles. In mode 1 the legal range of `div_cfg` is 23 to 3333, which is 4.5 MHz to 30 kHz at 200 MHz. In mode 0 any value of 1 or more is legal. A start request with an illegal value produces a one-cycle `cfg_reject` on the next edge and no strobe.
- R7: `rd_n` is low only during the 16-period read window and high at all other times.
- R8: `res_valid` is a one-cycle pulse. It is raised on the same clock edge that drives `sclk` low for the sixteenth time, and `rd_n` returns high on that edge too.
- R9: If busy fails to rise and then fall within `TO_CYC` cycles of waiting, `to_err` is set and the controller returns to idle. `to_err` then stays set until reset.
- R10: Synchronous reset gives `rd_n`=1, `sclk`=0, `conv_start`=0, `res_valid`=0, `cfg_reject`=0 and `to_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a conversion and read |
| mode_sel | input | 1 | 0: read after conversion; 1: read during conversion with the generated clock |
| div_cfg | input | 16 | Shift-clock half period in clock cycles |
| busy_in | input | 1 | Converter busy indication (asynchronous) |
| sdata_in | input | 1 | Converter serial data |
| conv_start | output | 1 | Conversion-start strobe |
| rd_n | output | 1 | Read enable, active low; high leaves the converter output tri-stated |
| sclk | output | 1 | Shift clock (also the conversion clock in mode 1) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 14 | Assembled result |
| cfg_reject | output | 1 | One-cycle pulse when a start is refused for an illegal divider |
| to_err | output | 1 | Sticky busy-timeout flag |

## Verification
`conv_start` and `cfg_reject` are due on the edge after the request. The bench drives the request at a falling edge and reads both outputs at the next falling edge. `res_valid` is due on the edge that ends the sixteenth shift-clock period. The bench's converter model watches `sclk` at every falling clock edge, so it checks the result, the returned read enable and the fresh `sclk` fall in one sample. The half-period length, the count of rising edges in each window and any edges during busy are tallied by that model continuously rather than at fixed cycle numbers. Busy passes through a two-stage synchroniser, so the model's conversion length has slack against the timeout.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WHI,
    ST_WLO,
    ST_READ
  } sadc_st_t;

  // Legal divider check: ext=1 bounds the generated clock to [lo_hz, hi_hz].
  function automatic logic div_legal(input logic ext, input longint div,
                                     input longint clk_hz, input longint lo_hz,
                                     input longint hi_hz);
    longint dmin;
    longint dmax;
    dmin = (clk_hz + 2 * hi_hz - 1) / (2 * hi_hz);
    dmax = clk_hz / (2 * lo_hz);
    if (ext) return (div >= dmin) && (div <= dmax);
    return div != 0;
  endfunction

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
  parameter int DIV_W = 16,
  parameter int NPER  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise_ev,
  output logic             last_fall
);
  localparam int NW = $clog2(NPER + 1);

  logic [DIV_W-1:0] cnt;
  logic [NW-1:0]    nper;
  logic             tick;
  logic             fall_ev;

  assign tick      = run && (cnt == half - 1'b1);
  assign rise_ev   = tick && !sclk;
  assign fall_ev   = tick && sclk;
  assign last_fall = fall_ev && (nper == NW'(NPER - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
      nper <= '0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
      if (fall_ev && nper != NW'(NPER)) nper <= nper + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_sclk_rest_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int NB = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          take,
  input  logic          fin,
  input  logic          sdata,
  output logic [NB-1:0] res_data,
  output logic          res_valid
);
  localparam int BW = $clog2(NB + 1);

  logic [NB-1:0] sh;
  logic [BW-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bitcnt    <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (clr) begin
        bitcnt <= '0;
      end else if (take && bitcnt < BW'(NB)) begin
        sh     <= {sh[NB-2:0], sdata};
        bitcnt <= bitcnt + 1'b1;
      end
      if (fin) begin
        res_data  <= sh;
        res_valid <= 1'b1;
      end
    end
  end

  assert_word_complete_R3: assert property (@(posedge clk) disable iff (rst)
    fin |-> bitcnt == BW'(NB));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

endmodule

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int TO_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(TO_CYC);
  localparam logic [TW-1:0] LIM = TW'(TO_CYC - 1);

  logic [TW-1:0] cnt;

  assign expired = en && (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sadc_capture_ctrl.sv
module sadc_capture_ctrl #(
  parameter int     DIV_W  = 16,
  parameter int     NB     = 14,
  parameter int     NPER   = 16,
  parameter int     TO_CYC = 4096,
  parameter longint CLK_HZ = 200_000_000,
  parameter longint MIN_HZ = 30_000,
  parameter longint MAX_HZ = 4_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_sel,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             busy_in,
  input  logic             sdata_in,
  output logic             conv_start,
  output logic             rd_n,
  output logic             sclk,
  output logic             res_valid,
  output logic [NB-1:0]    res_data,
  output logic             cfg_reject,
  output logic             to_err
);
  import sadc_pkg::*;

  sadc_st_t         st;
  logic             mode_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_m, busy_s;
  logic             legal, acc_ev, rej_ev;
  logic             run, rise_ev, last_fall;
  logic             take, fin, wait_en, wait_exp;

  assign legal  = div_legal(mode_sel, longint'(div_cfg), CLK_HZ, MIN_HZ, MAX_HZ);
  assign acc_ev = (st == ST_IDLE) && start && !busy_s && legal;
  assign rej_ev = (st == ST_IDLE) && start && !busy_s && !legal;

  assign run     = (st == ST_READ) || (mode_q && st == ST_WLO);
  assign take    = rise_ev && (st == ST_READ);
  assign fin     = last_fall && (st == ST_READ);
  assign wait_en = (st == ST_WHI) || (st == ST_WLO);

  assign conv_start = (st == ST_CONV);
  assign rd_n       = (st != ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m <= 1'b0;
      busy_s <= 1'b0;
    end else begin
      busy_m <= busy_in;
      busy_s <= busy_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= 1'b0;
      div_q      <= DIV_W'(1);
      cfg_reject <= 1'b0;
      to_err     <= 1'b0;
    end else begin
      cfg_reject <= rej_ev;
      unique case (st)
        ST_IDLE: if (acc_ev) begin
          st     <= ST_CONV;
          mode_q <= mode_sel;
          div_q  <= div_cfg;
        end
        ST_CONV: st <= mode_q ? ST_READ : ST_WHI;
        ST_WHI: begin
          if (wait_exp) begin
            st     <= ST_IDLE;
            to_err <= 1'b1;
          end else if (busy_s) begin
            st <= ST_WLO;
          end
        end
        ST_WLO: begin
          if (wait_exp) begin
            st     <= ST_IDLE;
            to_err <= 1'b1;
          end else if (!busy_s) begin
            if (!mode_q) st <= ST_READ;
            else if (!sclk && !rise_ev) st <= ST_IDLE;
          end
        end
        ST_READ: if (last_fall) st <= mode_q ? ST_WLO : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  sadc_clkgen #(.DIV_W(DIV_W), .NPER(NPER)) u_clk (
    .clk(clk), .rst(rst), .run(run), .half(div_q),
    .sclk(sclk), .rise_ev(rise_ev), .last_fall(last_fall)
  );

  sadc_shifter #(.NB(NB)) u_sh (
    .clk(clk), .rst(rst), .clr(conv_start), .take(take), .fin(fin),
    .sdata(sdata_in), .res_data(res_data), .res_valid(res_valid)
  );

  sadc_timer #(.TO_CYC(TO_CYC)) u_to (
    .clk(clk), .rst(rst), .en(wait_en), .expired(wait_exp)
  );

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_strobe_needs_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> !$past(busy_s));

  assert_quiet_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && !mode_q) |-> !busy_s);

  assert_window_clocked_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> run);

  assert_reject_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_reject |-> !conv_start);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    to_err |=> to_err);

endmodule

// File: tb/sim_sadc_capture_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_sel = 1'b0;
  logic [15:0] div_cfg = 16'd1;
  logic        sdata_in = 1'b0;
  logic        busy_in;
  logic        conv_start, rd_n, sclk, res_valid, cfg_reject, to_err;
  logic [13:0] res_data;

  int checks = 0;
  int errors = 0;

  // converter model state
  logic        busy_m = 1'b0;
  logic        hold_busy = 1'b0;
  logic        no_busy = 1'b0;
  logic        fill_bit = 1'b0;
  logic        cur_mode = 1'b0;
  logic [13:0] out_word = 14'h0000;
  logic [13:0] next_word = 14'h0000;
  logic [13:0] got_word = 14'h0000;
  logic        prev_sclk = 1'b0;
  logic        busy_at_valid = 1'b0;
  int busy_len = 40;
  int bcnt = 0;
  int idx = 0;
  int hi_run = 0;
  int last_hi = 0;
  int rises_win = 0;
  int rises_busy = 0;
  int rises_out = 0;
  int conv_seen = 0;
  int got_n = 0;
  int cyc = 0;

  assign busy_in = busy_m | hold_busy;

  always #2.5 clk = ~clk;

  sadc_capture_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel), .div_cfg(div_cfg),
    .busy_in(busy_in), .sdata_in(sdata_in), .conv_start(conv_start), .rd_n(rd_n),
    .sclk(sclk), .res_valid(res_valid), .res_data(res_data),
    .cfg_reject(cfg_reject), .to_err(to_err)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model, evaluated away from the active edge
  always @(negedge clk) begin
    logic fell, rose;
    if (rst) begin
      busy_m = 1'b0; idx = 0; prev_sclk = 1'b0; sdata_in = 1'b0;
    end else begin
      if (conv_start) begin
        conv_seen++;
        if (!no_busy) begin busy_m = 1'b1; bcnt = busy_len; end
      end else if (busy_m) begin
        bcnt--;
        if (bcnt <= 0) begin busy_m = 1'b0; out_word = next_word; end
      end
      fell = prev_sclk && !sclk;
      rose = !prev_sclk && sclk;
      if (sclk) hi_run++;
      if (fell) begin last_hi = hi_run; hi_run = 0; end
      if (rose) begin
        if (!rd_n) rises_win++;
        else if (!cur_mode) rises_out++;
        if (!cur_mode && busy_in) rises_busy++;
      end
      if (res_valid) begin
        got_word = res_data;
        got_n++;
        busy_at_valid = busy_in;
        chk("R8 valid on 16th fall with rd_n high", fell && rd_n, {fell, rd_n}, 2'b11);
      end
      if (rd_n) idx = 0;
      else if (fell) idx++;
      sdata_in = rd_n ? 1'b0 : (idx < 14 ? out_word[13 - idx] : fill_bit);
      prev_sclk = sclk;
    end
  end

  task automatic wait_result(input int n0);
    for (int i = 0; i < 20000 && got_n == n0; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic m, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; mode_sel = m; div_cfg = d; cur_mode = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rd_n", rd_n == 1'b1, rd_n, 1);
    chk("R10 sclk", sclk == 1'b0, sclk, 0);
    chk("R10 conv_start", conv_start == 1'b0, conv_start, 0);
    chk("R10 res_valid", res_valid == 1'b0, res_valid, 0);
    chk("R10 cfg_reject/to_err", {cfg_reject, to_err} == 2'b00, {cfg_reject, to_err}, 0);
  endtask

  task automatic t_after(input logic [13:0] w, input logic [15:0] d, input logic fb);
    int n0;
    next_word = w; fill_bit = fb; busy_len = 40;
    rises_win = 0; rises_busy = 0; rises_out = 0; n0 = got_n;
    pulse_start(1'b0, d);
    chk("R1 strobe one edge after start", conv_start == 1'b1, conv_start, 1);
    @(negedge clk);
    chk("R1 strobe lasts one cycle", conv_start == 1'b0, conv_start, 0);
    wait_result(n0);
    chk("R3 after-mode word", got_word == w, got_word, w);
    chk("R2 16 rising edges", rises_win == 16, rises_win, 16);
    chk("R4 no clock in busy", rises_busy == 0 && rises_out == 0, rises_busy + rises_out, 0);
    chk("R6 half period", last_hi == int'(d), last_hi, d);
    repeat (4) @(negedge clk);
    chk("R7 rd_n high after window", rd_n == 1'b1, rd_n, 1);
    chk("R2 sclk rests low", sclk == 1'b0, sclk, 0);
  endtask

  task automatic t_during(input logic [13:0] w, input logic [13:0] exp, input logic [15:0] d);
    int n0;
    next_word = w; fill_bit = 1'b0; busy_len = 900;
    rises_win = 0; n0 = got_n;
    pulse_start(1'b1, d);
    chk("R1 strobe in mode 1", conv_start == 1'b1, conv_start, 1);
    wait_result(n0);
    chk("R5 previous word returned", got_word == exp, got_word, exp);
    chk("R5 read while busy", busy_at_valid == 1'b1, busy_at_valid, 1);
    chk("R2 16 rising edges in window", rises_win == 16, rises_win, 16);
    chk("R6 half period mode 1", last_hi == int'(d), last_hi, d);
    for (int i = 0; i < 3000 && busy_in; i++) @(negedge clk);
    repeat (int'(d) * 2 + 8) @(negedge clk);
    chk("R5 clock stopped low after busy", sclk == 1'b0, sclk, 0);
    chk("R7 rd_n high when idle", rd_n == 1'b1, rd_n, 1);
  endtask

  task automatic t_reject(input logic m, input logic [15:0] d);
    int c0;
    c0 = conv_seen;
    pulse_start(m, d);
    chk("R6 cfg_reject pulse", cfg_reject == 1'b1, cfg_reject, 1);
    repeat (20) @(negedge clk);
    chk("R6 no strobe on illegal divider", conv_seen == c0, conv_seen, c0);
  endtask

  task automatic t_busy_block();
    int c0;
    hold_busy = 1'b1;
    repeat (5) @(negedge clk);
    c0 = conv_seen;
    pulse_start(1'b0, 16'd3);
    repeat (20) @(negedge clk);
    chk("R1 start ignored while busy", conv_seen == c0, conv_seen, c0);
    hold_busy = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_timeout();
    no_busy = 1'b1; rises_win = 0;
    pulse_start(1'b0, 16'd3);
    chk("R9 no error before wait", to_err == 1'b0, to_err, 0);
    for (int i = 0; i < 6000 && !to_err; i++) @(negedge clk);
    chk("R9 timeout flag", to_err == 1'b1, to_err, 1);
    chk("R9 no read on timeout", rises_win == 0 && rd_n, rises_win, 0);
    no_busy = 1'b0;
    repeat (5) @(negedge clk);
    t_after(14'h1234, 16'd2, 1'b0);
    chk("R9 flag sticky", to_err == 1'b1, to_err, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_after(14'h2A5C, 16'd3, 1'b0);
    t_after(14'h1FFF, 16'd1, 1'b1);   // fill bits 1: R3 discard
    t_after(14'h0001, 16'd5, 1'b1);
    t_during(14'h3C3C, 14'h0001, 16'd23);
    t_during(14'h0F0F, 14'h3C3C, 16'd24);
    t_reject(1'b1, 16'd22);
    t_reject(1'b1, 16'd3334);
    t_reject(1'b0, 16'd0);
    t_busy_block();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule